// File: doc/BRIEF.md
# Multicast Hash Group Filter

This block sits on the receive path and decides whether a frame addressed to a group (multicast) destination should be kept. It takes the six destination-address bytes in the order they arrive on the wire and runs a CRC-32 over them. The top byte of the CRC is an 8-bit index into a 256-entry bit table, and that table bit is the verdict. The table is held in eight 32-bit registers that software loads through a simple write port.

Upstream logic presents one address byte per `byte_valid_i` strobe. Idle cycles between bytes are allowed. After the sixth byte, `done_o` pulses for one cycle and `match_o` gives the verdict. `match_o` holds that value until the first byte of the next address is accepted. Every address is exactly six bytes long. The byte counter wraps after the sixth byte, so the next strobed byte always starts a new address.

Top module: `mhf_group_filter`

## Requirements
- R1: The hash is a CRC-32 over exactly six bytes: generator 0x04C11DB7, start value 0xFFFFFFFF, bits of each byte fed least significant first, each step being feedback = crc[31] xor data bit, crc shifted left by one, and the generator xored in when the feedback is 1. The result is not complemented and the index is crc[31:24].
- R2: Index bits [7:5] choose table register 0..7. Index bits [4:0] choose bit (31 - index[4:0]) of that register, so entry 0 is bit 31 of register 0 and entry 255 is bit 0 of register 7.
- R3: After reset all table registers are zero, so no address matches, and `match_o` and `done_o` are 0.
- R4: `match_o` is 1 only when bit 0 of the first address byte is 1 (group address) and the selected table bit is 1. An individual address (bit 0 = 0) never matches.
- R5: `done_o` is 1 for exactly one cycle, the cycle after the clock edge that accepts the sixth byte.
- R6: `match_o` becomes valid together with `done_o`, holds its value until the edge that accepts the next first byte, and is 0 while a new address is being collected.
- R7: With `wr_en_i` = 1, `wr_data_i` replaces all 32 bits of register `wr_idx_i` at the clock edge. With `wr_en_i` = 0, the write inputs have no effect on the table.
- R8: Idle cycles (`byte_valid_i` = 0) before, between or after address bytes do not change the hash, the verdict or the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Destination-address byte, wire order |
| byte_valid_i | input | 1 | `byte_i` carries a byte this cycle |
| wr_en_i | input | 1 | Table register write enable |
| wr_idx_i | input | 3 | Table register number |
| wr_data_i | input | 32 | Table register write value |
| match_o | output | 1 | Address accepted by the filter |
| done_o | output | 1 | One-cycle pulse: verdict available |

## Verification
The bench builds the block with its default parameters: six address bytes, an 8-bit index and 32-bit registers. With those values the whole 256-entry table can be covered. For each entry, the bench places a single set bit at that entry and uses its own CRC model to search for a group address whose hash lands there. It then checks that this address matches and that an address hashing to the neighbouring entry does not. Further runs cover an all-ones table with group and individual addresses, idle gaps inside an address, the done pulse and match hold, and writes issued with the enable low.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

  // One byte, LSB first, MSB-side feedback, no final inversion
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                      input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
  import mhf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_next_o
);
  logic [CRC_W-1:0] crc_q;

  assign crc_next_o = crc_step_byte(restart_i ? CRC_INIT : crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_INIT;
    else if (en_i) crc_q <= crc_next_o;
  end

  assert_crc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(crc_q));
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned REG_W = 32,
  localparam int unsigned BIT_W = $clog2(REG_W),
  localparam int unsigned SEL_W = IDX_W - BIT_W,
  localparam int unsigned NUM_REGS = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_idx_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[r] <= '0;
      else if (wr_en_i && wr_idx_i == SEL_W'(r)) regs_q[r] <= wr_data_i;
    end

    assert_reg_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == SEL_W'(r)) |=> regs_q[r] == $past(wr_data_i));
    assert_reg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_idx_i == SEL_W'(r)) |=> $stable(regs_q[r]));
  end

  logic [SEL_W-1:0] reg_sel;
  logic [BIT_W-1:0] bit_sel;
  // MSB-first numbering: bit (REG_W-1 - low) == ~low
  assign reg_sel = idx_i[IDX_W-1:BIT_W];
  assign bit_sel = ~idx_i[BIT_W-1:0];
  assign hit_o   = regs_q[reg_sel][bit_sel];
endmodule

// File: rtl/mhf_frame_ctl.sv
module mhf_frame_ctl #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic grp_bit_i,
  input  logic hit_i,
  output logic first_o,
  output logic match_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic grp_q, match_q, done_q;
  logic last;

  assign first_o = (cnt_q == '0);
  assign last    = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      grp_q   <= 1'b0;
      match_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= valid_i && last;
      if (valid_i) begin
        cnt_q <= last ? '0 : cnt_q + 1'b1;
        if (first_o) begin
          grp_q   <= grp_bit_i;
          match_q <= 1'b0;
        end
        if (last) match_q <= hit_i && (first_o ? grp_bit_i : grp_q);
      end
    end
  end

  assign match_o = match_q;
  assign done_o  = done_q;

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_match_needs_group_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> grp_q);
  assert_match_rise_at_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> done_o);
  assert_match_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(match_o));
endmodule

// File: rtl/mhf_group_filter.sv
module mhf_group_filter
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned REG_W = 32,
  localparam int unsigned BIT_W = $clog2(REG_W),
  localparam int unsigned SEL_W = IDX_W - BIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_idx_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             match_o,
  output logic             done_o
);
  logic [CRC_W-1:0] crc_next;
  logic             first;
  logic             hit;

  mhf_crc_acc u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (byte_valid_i),
    .restart_i  (first),
    .byte_i     (byte_i),
    .crc_next_o (crc_next)
  );

  mhf_hash_table #(.IDX_W(IDX_W), .REG_W(REG_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .idx_i     (crc_next[CRC_W-1 -: IDX_W]),
    .hit_o     (hit)
  );

  mhf_frame_ctl #(.ADDR_BYTES(ADDR_BYTES)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (byte_valid_i),
    .grp_bit_i (byte_i[0]),
    .hit_i     (hit),
    .first_o   (first),
    .match_o   (match_o),
    .done_o    (done_o)
  );

  assert_no_match_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && first) |=> !match_o);
endmodule

// File: tb/tb_mhf_group_filter.sv
module tb_mhf_group_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        byte_v = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        match, done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] shadow [8];
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  mhf_group_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_d), .byte_valid_i(byte_v),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .match_o(match), .done_o(done)
  );

  function automatic logic [7:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0] b;
    logic f;
    for (int k = 0; k < 6; k++) begin
      b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        f = c[31] ^ b[j];
        c = c << 1;
        if (f) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:24];
  endfunction

  function automatic logic expect_match(input logic [47:0] a);
    logic [7:0] ix = hidx(a);
    return a[40] && shadow[ix[7:5]][31 - int'(ix[4:0])];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[r] = d;
  endtask

  task automatic next_rand(output logic [31:0] v);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    v = lcg;
  endtask

  // Send six bytes; gap>0 inserts idle cycles after each byte
  task automatic send(input logic [47:0] a, input int gap);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byte_d = a[47-8*k -: 8];
      byte_v = 1'b1;
      @(negedge clk);
      byte_v = 1'b0;
      byte_d = 8'hA5;
      if (k < 5) for (int g = 0; g < gap; g++) @(negedge clk);
    end
    // now one cycle after the sixth byte's edge, away from the edge
  endtask

  task automatic send_check(input logic [47:0] a, input int gap, input string req);
    send(a, gap);
    chk("R5 done high", done, 1'b1);
    chk(req, match, expect_match(a));
  endtask

  task automatic find_addr(input logic [7:0] ix, input logic grp, output logic [47:0] a);
    logic [31:0] r0, r1;
    for (int t = 0; t < 20000; t++) begin
      next_rand(r0); next_rand(r1);
      a = {r0[31:16], r1};
      a[40] = grp;
      if (hidx(a) == ix) return;
    end
    n_tests++; n_fail++;
    $display("FAIL R1: no address for index %0d actual none expected one", ix);
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] a, b;
    logic [31:0] r;
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk("R3 reset match", match, 1'b0);
    chk("R3 reset done", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: empty table rejects group addresses
    for (int i = 0; i < 16; i++) begin
      next_rand(r); a = {r[15:0] | 16'h0100, r ^ 32'h5A5A_0000};
      send_check(a, 0, "R3 empty table");
    end

    // R4: all-ones table, group vs individual
    for (int i = 0; i < 8; i++) wr(i, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) begin
      next_rand(r); a = {r[31:16], r};
      a[40] = i[0];
      send_check(a, 0, "R4 group bit");
    end

    // R5/R6: done one cycle, match held over idle
    find_addr(8'd77, 1'b1, a);
    send(a, 0);
    chk("R5 done pulse", done, 1'b1);
    chk("R6 match valid", match, 1'b1);
    @(negedge clk);
    chk("R5 done clears", done, 1'b0);
    repeat (5) @(negedge clk);
    chk("R6 match held", match, 1'b1);
    @(negedge clk);
    byte_d = 8'h01; byte_v = 1'b1;
    @(negedge clk);
    byte_v = 1'b0;
    chk("R6 cleared on new first byte", match, 1'b0);
    for (int k = 1; k < 6; k++) begin
      @(negedge clk); byte_d = 8'h00; byte_v = 1'b1;
      @(negedge clk); byte_v = 1'b0;
    end
    chk("R5 done after wrap", done, 1'b1);

    // R8: idle gaps inside an address
    for (int i = 0; i < 6; i++) begin
      next_rand(r); a = {r[31:16] | 16'h0100, r};
      send_check(a, i + 1, "R8 gaps");
    end

    // R7: write with enable low has no effect
    for (int i = 0; i < 8; i++) wr(i, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 3'd2; wr_data = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    find_addr(8'd70, 1'b1, a);   // index 70 -> register 2
    send_check(a, 0, "R7 disabled write ignored");
    chk("R7 disabled write ignored no match", match, 1'b0);

    // R1/R2: walk every table entry
    for (int e = 0; e < 256; e++) begin
      if (e % 32 == 0 && e != 0) wr(e / 32 - 1, 32'h0);
      wr(e / 32, 32'h8000_0000 >> (e % 32));
      find_addr(8'(e), 1'b1, a);
      send(a, 0);
      chk("R2 selected entry hits", match, 1'b1);
      find_addr(8'(e ^ 1), 1'b1, b);
      send(b, 0);
      chk("R1 neighbour entry misses", match, 1'b0);
      if (e == 0) chk("R2 entry0 is reg0 bit31", shadow[0][31], 1'b1);
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule